// File: doc/BRIEF.md
# GPIO Bank Controller with Per-Pin Interrupt Detection

This block controls one bank of general-purpose pins through a small word-addressed register bus. Each pin has an output data bit, a direction bit that turns its output driver on, and a readable pad level taken from the live pin input. Software writes the data and direction words to drive pins. It reads the pad word to see what is actually on the wires.

Every pin can also raise an interrupt. A 2-bit trigger field per pin selects low level, high level, rising edge or falling edge. A per-pin any-edge override makes both transitions count. Each hit latches a sticky status bit, which stays set until software writes a one to it. A mask word decides which status bits reach the two request lines: one line serves the lower half of the bank and one the upper half. Pin inputs pass through a synchronizer before any detection.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every register (data, direction, trigger, mask, status, any-edge) and drives pin_out, pin_oe, irq_lo, irq_hi and bus_rdata to zero.
- R2: A write to word 0x00 sets pin_out, and a write to word 0x04 sets pin_oe (bit n = 1 makes pin n an output), both from the next clock edge. Both words read back as written.
- R3: Word 0x08 reads the pin input levels after a two-flop synchronizer, not the data register. Writes to 0x08 change nothing.
- R4: Trigger fields are 2 bits per pin. Pins 0-15 sit in word 0x0C and pins 16-31 in word 0x10, with pin n at bits [2(n mod 16)+1 : 2(n mod 16)]. Code 0 sets status while the synchronized pin is low, and code 1 sets it while the pin is high.
- R5: Code 2 sets status when the synchronized pin goes from 0 to 1 between consecutive clocks, and code 3 when it goes from 1 to 0. A steady level does not set status in these modes.
- R6: When bit n of word 0x1C is 1, either transition of pin n sets its status and the pin's trigger field is ignored.
- R7: Status (word 0x18) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it. If a hit and a clear land in the same cycle, the hit wins, so a level condition that still holds leaves the bit set.
- R8: Status bits are set by their trigger condition whatever the mask holds.
- R9: Mask is word 0x14, where 1 enables a pin. irq_lo equals the OR of (status AND mask) over bits 0-15 one clock earlier, and irq_hi does the same over bits 16-31.
- R10: bus_rdata is registered. It takes the addressed word at the clock edge where bus_rd is high and holds otherwise. An address with any bit above bit 4 set, or with bits [1:0] non-zero, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register word |
| bus_wdata | input | NUM_PINS (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data valid the next cycle |
| bus_rdata | output | NUM_PINS (32) | Registered read data |
| pin_in | input | NUM_PINS (32) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (32) | Output data to the pads |
| pin_oe | output | NUM_PINS (32) | Output enables, 1 = drive |
| irq_lo | output | 1 | Request for pins 0-15 |
| irq_hi | output | 1 | Request for pins 16-31 |

## Verification
The bench builds the block with its default values: 32 pins, an 8-bit address and two synchronizer stages. With these values both trigger words, both request halves and the out-of-range address decode are all reachable. Pin 3 covers the level modes in the low half, and pin 20 covers the edge modes and the any-edge override in the high half. This shows each request line reacting only to its own half and to the mask.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_e;

  // word index = byte address [4:2]
  localparam logic [2:0] W_DATA   = 3'd0;
  localparam logic [2:0] W_DIR    = 3'd1;
  localparam logic [2:0] W_PAD    = 3'd2;
  localparam logic [2:0] W_TRG_LO = 3'd3;
  localparam logic [2:0] W_TRG_HI = 3'd4;
  localparam logic [2:0] W_MASK   = 3'd5;
  localparam logic [2:0] W_STAT   = 3'd6;
  localparam logic [2:0] W_ANYEDG = 3'd7;

  function automatic logic trig_hit(input logic [1:0] mode, input logic any_edge,
                                    input logic cur, input logic prv);
    logic r;
    if (any_edge) begin
      r = cur ^ prv;
    end else begin
      unique case (trig_mode_e'(mode))
        TRIG_LOW:  r = ~cur;
        TRIG_HIGH: r = cur;
        TRIG_RISE: r = cur & ~prv;
        TRIG_FALL: r = ~cur & prv;
        default:   r = 1'b0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   cur,
  input  logic [2*NUM_PINS-1:0] trig_cfg,
  input  logic [NUM_PINS-1:0]   any_edge,
  output logic [NUM_PINS-1:0]   hit
);
  logic [NUM_PINS-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) prv_q <= '0;
    else     prv_q <= cur;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign hit[p] = trig_hit(trig_cfg[2*p +: 2], any_edge[p], cur[p], prv_q[p]);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_PINS-1:0]   wdata,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [NUM_PINS-1:0]   pad,
  input  logic [NUM_PINS-1:0]   hit,
  output logic [NUM_PINS-1:0]   data_q,
  output logic [NUM_PINS-1:0]   dir_q,
  output logic [2*NUM_PINS-1:0] trig_q,
  output logic [NUM_PINS-1:0]   mask_q,
  output logic [NUM_PINS-1:0]   anyedge_q,
  output logic [NUM_PINS-1:0]   stat_q,
  output logic [NUM_PINS-1:0]   rdata
);
  logic       in_range;
  logic [2:0] word;
  logic       wr_hit;
  logic [NUM_PINS-1:0] clr_bits;
  logic [NUM_PINS-1:0] rd_mux;

  assign in_range = (addr[ADDR_W-1:5] == '0) && (addr[1:0] == 2'b00);
  assign word     = addr[4:2];
  assign wr_hit   = wr && in_range;
  assign clr_bits = (wr_hit && word == W_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      dir_q     <= '0;
      trig_q    <= '0;
      mask_q    <= '0;
      anyedge_q <= '0;
    end else if (wr_hit) begin
      unique case (word)
        W_DATA:   data_q <= wdata;
        W_DIR:    dir_q <= wdata;
        W_TRG_LO: trig_q[NUM_PINS-1:0] <= wdata;
        W_TRG_HI: trig_q[2*NUM_PINS-1:NUM_PINS] <= wdata;
        W_MASK:   mask_q <= wdata;
        W_ANYEDG: anyedge_q <= wdata;
        default:  ;
      endcase
    end
  end

  // hit wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_bits) | hit;
  end

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (word)
        W_DATA:   rd_mux = data_q;
        W_DIR:    rd_mux = dir_q;
        W_PAD:    rd_mux = pad;
        W_TRG_LO: rd_mux = trig_q[NUM_PINS-1:0];
        W_TRG_HI: rd_mux = trig_q[2*NUM_PINS-1:NUM_PINS];
        W_MASK:   rd_mux = mask_q;
        W_STAT:   rd_mux = stat_q;
        W_ANYEDG: rd_mux = anyedge_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_lo,
  output logic                irq_hi
);
  localparam int HALF    = NUM_PINS / 2;
  localparam int N_LINES = 2;

  logic [NUM_PINS-1:0]   pad_sync;
  logic [NUM_PINS-1:0]   hit_w;
  logic [2*NUM_PINS-1:0] trig_w;
  logic [NUM_PINS-1:0]   mask_w;
  logic [NUM_PINS-1:0]   anyedge_w;
  logic [NUM_PINS-1:0]   stat_w;
  logic [N_LINES-1:0]    line_d;
  logic [N_LINES-1:0]    line_q;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pad_sync)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .cur(pad_sync), .trig_cfg(trig_w),
    .any_edge(anyedge_w), .hit(hit_w)
  );

  gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .pad(pad_sync), .hit(hit_w),
    .data_q(pin_out), .dir_q(pin_oe), .trig_q(trig_w), .mask_q(mask_w),
    .anyedge_q(anyedge_w), .stat_q(stat_w), .rdata(bus_rdata)
  );

  for (genvar h = 0; h < N_LINES; h++) begin : g_line
    assign line_d[h] = |(stat_w[h*HALF +: HALF] & mask_w[h*HALF +: HALF]);
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_d;
  end

  assign irq_lo = line_q[0];
  assign irq_hi = line_q[1];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [NUM_PINS-1:0] bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq_lo,
  input logic                irq_hi,
  input logic [NUM_PINS-1:0] stat_q,
  input logic [NUM_PINS-1:0] mask_q
);
  localparam int HALF = NUM_PINS / 2;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h18);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && !irq_lo && !irq_hi && bus_rdata == '0));

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA) |=> pin_out == $past(bus_wdata));

  // R7
  sticky_stat_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R9
  irq_lo_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_lo == $past(|(stat_q[HALF-1:0] & mask_q[HALF-1:0])));

  // R9
  irq_hi_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_hi == $past(|(stat_q[NUM_PINS-1:HALF] & mask_q[NUM_PINS-1:HALF])));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .stat_q(stat_w), .mask_q(mask_w)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_lo, irq_hi;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [31:0] rv;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_s1, m_s2, m_prev, m_data, m_dir, m_tlo, m_thi, m_mask, m_stat, m_any, m_rdata;
  logic m_irq_lo, m_irq_hi;
  bit   model_live = 0;

  always @(posedge clk) begin
    logic [31:0] hits, nxt_rd;
    int md;
    bit c, p;
    model_live = 1;
    if (rst) begin
      {m_s1, m_s2, m_prev, m_data, m_dir, m_tlo, m_thi, m_mask, m_stat, m_any, m_rdata} = '0;
      m_irq_lo = 0; m_irq_hi = 0;
    end else begin
      hits = 0;
      for (int i = 0; i < 32; i++) begin
        c = m_s2[i]; p = m_prev[i];
        md = (i < 16) ? ((m_tlo >> (2*i)) & 3) : ((m_thi >> (2*(i-16))) & 3);
        if (m_any[i]) hits[i] = (c != p);
        else if (md == 0) hits[i] = !c;
        else if (md == 1) hits[i] = c;
        else if (md == 2) hits[i] = c && !p;
        else hits[i] = !c && p;
      end
      case (bus_addr)
        8'h00: nxt_rd = m_data;   8'h04: nxt_rd = m_dir;
        8'h08: nxt_rd = m_s2;     8'h0C: nxt_rd = m_tlo;
        8'h10: nxt_rd = m_thi;    8'h14: nxt_rd = m_mask;
        8'h18: nxt_rd = m_stat;   8'h1C: nxt_rd = m_any;
        default: nxt_rd = 0;
      endcase
      if (bus_rd) m_rdata = nxt_rd;
      m_irq_lo = (m_stat[15:0] & m_mask[15:0]) != 0;
      m_irq_hi = (m_stat[31:16] & m_mask[31:16]) != 0;
      if (bus_wr && bus_addr == 8'h18) m_stat = m_stat & ~bus_wdata;
      m_stat = m_stat | hits;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_data = bus_wdata;  8'h04: m_dir = bus_wdata;
          8'h0C: m_tlo = bus_wdata;   8'h10: m_thi = bus_wdata;
          8'h14: m_mask = bus_wdata;  8'h1C: m_any = bus_wdata;
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (model_live) begin
      check("R2 pin_out", pin_out, m_data);
      check("R2 pin_oe", pin_oe, m_dir);
      check("R9 irq_lo", {31'b0, irq_lo}, {31'b0, m_irq_lo});
      check("R9 irq_hi", {31'b0, irq_hi}, {31'b0, m_irq_hi});
      check("R10 bus_rdata", bus_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    // R1
    check("R1 pin_out after reset", pin_out, 0);
    check("R1 pin_oe after reset", pin_oe, 0);
    check("R1 irq lines after reset", {30'b0, irq_hi, irq_lo}, 0);
    rd(8'h14, rv); check("R1 mask reset", rv, 0);
    idle(2);
    rd(8'h18, rv); check("R4 low-level default sets all status", rv, 32'hFFFF_FFFF);

    // R2
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_0000);
    check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(8'h04, rv); check("R2 dir readback", rv, 32'hFFFF_0000);

    // R3
    pin_in = 32'h1234_5678;
    idle(3);
    rd(8'h08, rv); check("R3 pad level", rv, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, rv); check("R3 pad write ignored", rv, 32'h1234_5678);

    // R4 high level, R8 unmasked
    pin_in = 0;
    wr(8'h0C, 32'h5555_5555);
    wr(8'h10, 32'h5555_5555);
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    idle(2);
    rd(8'h18, rv); check("R4 high level, pins low", rv, 0);
    pin_in = 32'h8;
    idle(4);
    rd(8'h18, rv); check("R4 high level pin3", rv, 32'h8);
    check("R8 masked status keeps irq_lo low", {31'b0, irq_lo}, 0);
    wr(8'h14, 32'h0010_0008);
    idle(2);
    check("R9 irq_lo raised", {31'b0, irq_lo}, 1);
    check("R9 irq_hi quiet", {31'b0, irq_hi}, 0);
    rd(8'h14, rv); check("R9 mask readback", rv, 32'h0010_0008);
    // R7 level re-set
    wr(8'h18, 32'h8);
    rd(8'h18, rv); check("R7 level holds through clear", rv, 32'h8);
    pin_in = 0;
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    idle(2);
    rd(8'h18, rv); check("R7 cleared", rv, 0);
    check("R9 irq_lo dropped", {31'b0, irq_lo}, 0);

    // R4 low level on pin 0
    wr(8'h0C, 32'h5555_5554);
    idle(2);
    rd(8'h18, rv); check("R4 low level pin0", rv, 32'h1);
    pin_in = 32'h1;
    idle(4);
    wr(8'h18, 32'h1);
    idle(1);
    rd(8'h18, rv); check("R7 write-one clear", rv, 0);
    pin_in = 0;
    wr(8'h0C, 32'h5555_5555);
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);

    // R5 rising on pin 20
    wr(8'h10, 32'h5555_5655);
    idle(2);
    pin_in = 32'h0010_0000;
    idle(5);
    rd(8'h18, rv); check("R5 rise pin20", rv, 32'h0010_0000);
    check("R9 irq_hi raised", {31'b0, irq_hi}, 1);
    check("R9 irq_lo quiet", {31'b0, irq_lo}, 0);
    wr(8'h18, 32'h0010_0000);
    idle(3);
    rd(8'h18, rv); check("R5 steady high no re-set", rv, 0);
    pin_in = 0;
    idle(4);
    rd(8'h18, rv); check("R5 fall ignored in rise mode", rv, 0);
    // falling
    wr(8'h10, 32'h5555_5755);
    pin_in = 32'h0010_0000;
    idle(4);
    rd(8'h18, rv); check("R5 rise ignored in fall mode", rv, 0);
    pin_in = 0;
    idle(4);
    rd(8'h18, rv); check("R5 fall pin20", rv, 32'h0010_0000);
    wr(8'h18, 32'hFFFF_FFFF);

    // R6 any edge overrides fall mode
    wr(8'h1C, 32'h0010_0000);
    idle(2);
    rd(8'h18, rv); check("R6 no edge no status", rv, 0);
    pin_in = 32'h0010_0000;
    idle(4);
    rd(8'h18, rv); check("R6 rise with any-edge", rv, 32'h0010_0000);
    wr(8'h18, 32'h0010_0000);
    pin_in = 0;
    idle(4);
    rd(8'h18, rv); check("R6 fall with any-edge", rv, 32'h0010_0000);
    rd(8'h1C, rv); check("R6 any-edge readback", rv, 32'h0010_0000);
    wr(8'h18, 32'hFFFF_FFFF);

    // R10
    rd(8'h20, rv); check("R10 out of range reads zero", rv, 0);
    rd(8'h01, rv); check("R10 misaligned reads zero", rv, 0);
    wr(8'h20, 32'h1111_1111);
    wr(8'h01, 32'h2222_2222);
    rd(8'h00, rv); check("R10 stray writes ignored", rv, 32'hA5A5_0F0F);
    idle(3);
    check("R10 rdata holds", bus_rdata, 32'hA5A5_0F0F);

    idle(2);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule